// File: doc/BRIEF.md
# Key-Locked Folded IIR Filter

This block filters a stream of 16-bit signed samples with a cascade of identical third-order IIR sections. Only one section's arithmetic exists in hardware. It is reused over successive cycles, one cycle per section, so that l sections form a filter of order 3·l, with l anywhere from 1 to 8. Seven programmable coefficients are shared by every section. Each section keeps its own three state words.

Which cascade runs depends on two things. The first is a short key sequence delivered on a symbol stream, which a small state machine must see in order. The second is a 128-bit configuration word, which is compared against one stored pattern per order. Until the key has been accepted, the filter still produces output, but in a scrambled default mode. After the key has been accepted, a matching configuration word selects a clean cascade of l sections. That cascade may or may not be the order the application expects, but its output is plausible either way. A configuration word that matches no pattern falls back to the scrambled mode.

In the scrambled mode, two sections run and each one reads its state from the wrong section. The output then looks like a filter's output but is not the intended response.

Top module: `keyed_folded_iir`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, all section states are zero and the key is not accepted.
- R2: Key symbols are checked only when key_valid is 1. Symbol i must equal KEY_SEQ[8i+7:8i], taking i = 0 first. A match advances to the next symbol. Any mismatch returns to symbol 0, including a mismatching symbol that equals symbol 0. After KEY_LEN consecutive matches the key is accepted. It stays accepted until reset, and later key symbols have no effect.
- R3: While the key is not accepted, every sample is processed in the scrambled mode of R5, whatever cfg_word holds, and outputs keep appearing.
- R4: Once the key is accepted, a cfg_word equal to CFG_TAG XOR sixteen copies of the byte (l·CFG_STEP mod 256) selects a clean cascade of l sections (order 3·l) for l in 1..8. In a clean cascade, section k reads and writes its own state.
- R5: The scrambled mode uses NM_L sections, with NM_L = 2 by default. It is selected by a locked key or by an unmatched cfg_word. In this mode, section k computes from the state of section (k+1) mod NM_L and writes its results into section k's own state.
- R6: Each section takes input x and read states s0, s1, s2, with coefficients packed in coef from the least significant bits upward as b0, b1, b2, b3, a1, a2, a3. It computes y = sat((b0·x + s0) >>> 14), then new s0 = b1·x − a1·y + s1, new s1 = b2·x − a2·y + s2, and new s2 = b3·x − a3·y. All sums are 32-bit wrapping and the shift is arithmetic.
- R7: sat() clamps to the range −32768..32767. The clamped y is the input to the next section, and the last section's y is out_data.
- R8: A sample is accepted on a clock edge where in_valid and in_ready are both 1. With in_valid held high, a new sample is accepted every l cycles.
- R9: Each accepted sample yields exactly one out_valid pulse, l cycles after its acceptance edge, in acceptance order. The mode is sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key symbol strobe |
| key_sym | input | 8 | Key symbol |
| cfg_word | input | 128 | Configuration word that selects the mode |
| coef | input | 112 | Seven packed signed coefficients, scaled by 2^14 |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Block can accept a sample this cycle |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Signed filtered sample |

## Verification
A wrong key state or a wrong mode decode never shows as a flag. It shows as a different sequence of output values. With a feedback filter, the difference normally appears on the first output after acceptance, that is, l cycles later, and it persists through the stored state. A wrong section count also shifts the spacing of in_ready and out_valid within the first sample period. For this reason the bench drives every scenario through a full stream and compares each output value and the output spacing against an independent model of the section arithmetic.

// File: rtl/keyed_folded_iir.sv
module keyed_folded_iir #(
  parameter int DW       = 16,
  parameter int AW       = 32,
  parameter int FRAC     = 14,
  parameter int L_MAX    = 8,
  parameter int NM_L     = 2,
  parameter int KEY_W    = 8,
  parameter int KEY_LEN  = 4,
  parameter logic [KEY_W*KEY_LEN-1:0] KEY_SEQ = 32'h7BE13CA5,
  parameter int CFG_W    = 128,
  parameter logic [CFG_W-1:0] CFG_TAG = 128'h3F0A9C51D2E84B760C1FA3E59D27684B,
  parameter logic [7:0]  CFG_STEP = 8'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key_sym,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [7*DW-1:0]   coef,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);
  localparam int LW  = $clog2(L_MAX + 1);
  localparam int SW  = (L_MAX > 1) ? $clog2(L_MAX) : 1;
  localparam int KCW = $clog2(KEY_LEN + 1);
  localparam int CB  = CFG_W / 8;
  localparam logic signed [AW-1:0] YMAX = AW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [AW-1:0] YMIN = -AW'(1 <<< (DW - 1));

  logic [KCW-1:0] key_cnt;
  logic           unlocked;
  wire  [KEY_W-1:0] key_exp = KEY_SEQ[int'(key_cnt)*KEY_W +: KEY_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_cnt  <= '0;
      unlocked <= 1'b0;
    end else if (key_valid && !unlocked) begin
      if (key_sym == key_exp) begin
        if (key_cnt == KCW'(KEY_LEN - 1)) unlocked <= 1'b1;
        else key_cnt <= key_cnt + KCW'(1);
      end else begin
        key_cnt <= '0;
      end
    end
  end

  function automatic logic [CFG_W-1:0] mode_pat(input int l);
    return CFG_TAG ^ {CB{8'(l * int'(CFG_STEP))}};
  endfunction

  logic [LW-1:0] sel_l;
  logic          sel_nm;
  always_comb begin
    sel_l  = LW'(NM_L);
    sel_nm = 1'b1;
    if (unlocked)
      for (int l = 1; l <= L_MAX; l++)
        if (cfg_word == mode_pat(l)) begin
          sel_l  = LW'(l);
          sel_nm = 1'b0;
        end
  end

  logic signed [DW-1:0] c [7];
  for (genvar i = 0; i < 7; i++) begin : g_coef
    assign c[i] = coef[i*DW +: DW];
  end

  logic                 busy, cur_nm;
  logic [LW-1:0]        slot, cur_l;
  logic signed [DW-1:0] x_q;
  logic signed [AW-1:0] st0 [L_MAX];
  logic signed [AW-1:0] st1 [L_MAX];
  logic signed [AW-1:0] st2 [L_MAX];

  wire last   = (slot == cur_l - LW'(1));
  wire accept = in_valid && in_ready;
  assign in_ready = !busy || last;

  wire [SW-1:0] wr_idx = slot[SW-1:0];
  wire [SW-1:0] rd_idx = !cur_nm ? slot[SW-1:0] : (last ? '0 : SW'(slot + LW'(1)));

  logic signed [AW-1:0] acc, n0, n1, n2;
  logic signed [DW-1:0] y;
  always_comb begin
    acc = c[0] * x_q + st0[rd_idx];
    acc = acc >>> FRAC;
    if (acc > YMAX)      y = YMAX[DW-1:0];
    else if (acc < YMIN) y = YMIN[DW-1:0];
    else                 y = acc[DW-1:0];
    n0 = c[1] * x_q - c[4] * y + st1[rd_idx];
    n1 = c[2] * x_q - c[5] * y + st2[rd_idx];
    n2 = c[3] * x_q - c[6] * y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_nm    <= 1'b1;
      slot      <= '0;
      cur_l     <= LW'(NM_L);
      x_q       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int k = 0; k < L_MAX; k++) begin
        st0[k] <= '0;
        st1[k] <= '0;
        st2[k] <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        st0[wr_idx] <= n0;
        st1[wr_idx] <= n1;
        st2[wr_idx] <= n2;
        if (last) begin
          out_valid <= 1'b1;
          out_data  <= y;
          busy      <= 1'b0;
        end else begin
          x_q  <= y;
          slot <= slot + LW'(1);
        end
      end
      if (accept) begin
        busy   <= 1'b1;
        slot   <= '0;
        x_q    <= in_data;
        cur_l  <= sel_l;
        cur_nm <= sel_nm;
      end
    end
  end

  // R2
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  // R3
  locked_scramble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !unlocked) |=> (cur_nm && cur_l == LW'(NM_L)));

  // R4
  order_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_l >= LW'(1) && cur_l <= LW'(L_MAX)));

  // R8
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot < cur_l));

  // R9
  out_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy && last));
endmodule

// File: tb/keyed_folded_iir_tb.sv
module keyed_folded_iir_tb;
  localparam logic [127:0] TAG  = 128'h3F0A9C51D2E84B760C1FA3E59D27684B;
  localparam int STEP = 29;
  localparam int NM_L = 2;
  localparam int NS   = 12;
  localparam logic signed [15:0] STIM [NS] = '{
    16'sd1000, -16'sd2000, 16'sd32767, 16'sd32767, -16'sd32768, 16'sd0,
    16'sd500, 16'sd12000, -16'sd7000, 16'sd32767, -16'sd32768, 16'sd3};
  localparam int C [7] = '{16384, 12288, 8192, 4096, -12288, 4096, -2048};

  logic         clk = 0, rst_n = 0, key_valid = 0, in_valid = 0;
  logic [7:0]   key_sym = '0;
  logic [127:0] cfg_word = '0;
  logic [111:0] coef;
  logic [15:0]  in_data = '0;
  logic         in_ready, out_valid;
  logic [15:0]  out_data;

  int n_chk = 0, n_bad = 0;
  int ms0 [8], ms1 [8], ms2 [8];
  int expq [NS];

  always #2 clk = ~clk;

  keyed_folded_iir u_dut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_sym(key_sym),
    .cfg_word(cfg_word), .coef(coef), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

  initial for (int i = 0; i < 7; i++) coef[i*16 +: 16] = 16'(C[i]);

  function automatic logic [127:0] pat(input int l);
    return TAG ^ {16{8'(l * STEP)}};
  endfunction

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input int x, input int l, input bit nm, output int yo);
    int v = x;
    for (int k = 0; k < l; k++) begin
      int rd = nm ? (k + 1) % l : k;
      int y  = sat((C[0] * v + ms0[rd]) >>> 14);
      int a  = C[1] * v - C[4] * y + ms1[rd];
      int b  = C[2] * v - C[5] * y + ms2[rd];
      ms2[k] = C[3] * v - C[6] * y;
      ms0[k] = a;
      ms1[k] = b;
      v = y;
    end
    yo = v;
  endtask

  task automatic do_reset();
    rst_n = 0;
    key_valid = 0;
    in_valid = 0;
    for (int k = 0; k < 8; k++) begin ms0[k] = 0; ms1[k] = 0; ms2[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic send_key(input logic [7:0] s);
    @(negedge clk);
    key_valid = 1;
    key_sym = s;
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic good_key();
    send_key(8'hA5); send_key(8'h3C); send_key(8'hE1); send_key(8'h7B);
  endtask

  // streams the stimulus table; checks values (R6 R7) and spacing (R8 R9)
  task automatic run_stream(input string tag, input int l, input bit nm);
    int sent = 0, got = 0, cyc = 0, last_out = -1;
    bit gap_ok = 1;
    int bad_gap = 0;
    while (got < NS && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (out_valid) begin
        chk($signed(out_data) == 16'(expq[got]), {tag, " R6 R7 value"},
            int'($signed(out_data)), expq[got]);
        if (last_out >= 0 && cyc - last_out != l) begin gap_ok = 0; bad_gap = cyc - last_out; end
        last_out = cyc;
        got++;
      end
      if (in_ready && sent < NS) begin
        int e;
        in_valid = 1;
        in_data = STIM[sent];
        model(int'(STIM[sent]), l, nm, e);
        expq[sent] = e;
        sent++;
      end else begin
        in_valid = 0;
      end
    end
    in_valid = 0;
    chk(got == NS, {tag, " R9 output count"}, got, NS);
    chk(gap_ok, {tag, " R8 sample spacing"}, bad_gap, l);
  endtask

  initial begin
    cfg_word = pat(3);
    do_reset();
    run_stream("locked R3", NM_L, 1);

    do_reset();
    send_key(8'hA5); send_key(8'h3C); send_key(8'hE1); send_key(8'h00); send_key(8'h7B);
    run_stream("wrong key R2", NM_L, 1);

    do_reset();
    send_key(8'hA5); send_key(8'h00); good_key();
    cfg_word = pat(3);
    run_stream("restart key R2 R4 l3", 3, 0);

    do_reset();
    good_key();
    cfg_word = pat(1);
    run_stream("R4 l1", 1, 0);

    do_reset();
    good_key();
    cfg_word = pat(8);
    run_stream("R4 l8", 8, 0);

    do_reset();
    good_key();
    cfg_word = pat(2);
    run_stream("R4 l2", 2, 0);

    do_reset();
    good_key();
    cfg_word = pat(5) ^ 128'h1;
    run_stream("unmatched R5", NM_L, 1);

    do_reset();
    good_key();
    send_key(8'h00); send_key(8'h11); send_key(8'hA5);
    cfg_word = pat(4);
    run_stream("after unlock R2", 4, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule